// File: doc/BRIEF.md
# Maskable Interrupt Enable Controller

This block keeps the enable bit for external maskable interrupts in a small processor core. The retire stage reports each finished instruction with a valid pulse and its opcode byte. When a set-enable or clear-enable instruction retires, the block first checks privilege. It uses four inputs for this: the protection-enable bit, the virtual-mode bit, the current privilege level and the I/O privilege level. If the instruction is permitted, the block updates the flag. If it is not, the block raises a general-protection fault with error code zero.

A permitted set that finds the flag clear also arms a one-instruction shadow. The instruction that retires next, typically a return, therefore always completes before an interrupt can be accepted. A clear that retires inside the shadow cancels the pending set, so no interrupt window opens.

The take-interrupt output is the external request gated by the flag and by the shadow. Non-maskable interrupts and exceptions are passed straight through, and neither the flag nor the shadow gates them.

Top module: `ief_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the flag, the shadow, take_intr and gp_fault are all 0.
- R2: A retire with opcode 0xFB (set) that is permitted drives ie_flag to 1 in the cycle after the retire edge. It leaves gp_fault at 0.
- R3: A permitted set that finds the flag clear drives ie_shadow to 1. While ie_shadow is 1, take_intr is 0. The next retire of any other opcode clears the shadow, after which take_intr equals ext_irq.
- R4: A permitted set that finds the flag already set leaves ie_shadow at 0. take_intr keeps following ext_irq.
- R5: A permitted retire with opcode 0xFA (clear) drives both ie_flag and ie_shadow to 0. A clear that retires right after a set therefore leaves take_intr at 0.
- R6: When prot_en is 0, set and clear are always permitted, whatever the privilege levels are.
- R7: When prot_en is 1 and virt_mode is 0, set and clear are permitted exactly when cpl is less than or equal to iopl.
- R8: When prot_en is 1 and virt_mode is 1, set and clear are permitted exactly when iopl equals 3. In this case cpl is ignored.
- R9: A set or clear that is not permitted drives gp_fault high for exactly one cycle, in the cycle after the retire edge, with gp_code 0. It leaves ie_flag and ie_shadow unchanged.
- R10: take_nmi equals nmi_req and take_exc equals exc_req in every cycle, whatever the flag and the shadow are.
- R11: A retire of any opcode other than 0xFB or 0xFA leaves ie_flag unchanged. When retire_vld is 0, the opcode is ignored and the flag and the shadow hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| retire_vld | input | 1 | One instruction retires this cycle |
| retire_op | input | 8 | Opcode of the retiring instruction |
| prot_en | input | 1 | Protection enabled |
| virt_mode | input | 1 | Virtual mode active |
| cpl | input | 2 | Current privilege level |
| iopl | input | 2 | I/O privilege level |
| ext_irq | input | 1 | External maskable interrupt request |
| nmi_req | input | 1 | Non-maskable interrupt request |
| exc_req | input | 1 | Exception request |
| ie_flag | output | 1 | Interrupt enable flag |
| ie_shadow | output | 1 | One-instruction shadow is active |
| take_intr | output | 1 | Accept the maskable interrupt |
| take_nmi | output | 1 | Accept the NMI |
| take_exc | output | 1 | Accept the exception |
| gp_fault | output | 1 | General-protection fault pulse |
| gp_code | output | 16 | Fault error code |

## Verification
The assertions hold in every cycle for these properties:
- The shadow always masks take_intr.
- A shadow can only start together with a rising flag.
- A rising flag always follows a retired set.
- A fault leaves the flag unchanged and carries code zero.
- NMI and exceptions pass through untouched.

Only the bench scenarios can show the rest:
- The full privilege decision, swept over every combination of protection, virtual mode and both privilege levels, for both the set and the clear opcode.
- The timing of the one-instruction shadow.
- A clear right after a set cancelling the set.

// File: rtl/ief_pkg.sv
package ief_pkg;
    localparam int OP_W  = 8;
    localparam int PL_W  = 2;
    localparam int ERR_W = 16;

    localparam logic [OP_W-1:0]  OP_SET_IE = 8'hFB;
    localparam logic [OP_W-1:0]  OP_CLR_IE = 8'hFA;
    localparam logic [ERR_W-1:0] GP_ERR_ZERO = '0;
    localparam logic [PL_W-1:0]  PL_LEAST = {PL_W{1'b1}};

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SET,
        CMD_CLR
    } ie_cmd_e;

    typedef struct packed {
        logic            pe;
        logic            vm;
        logic [PL_W-1:0] cpl;
        logic [PL_W-1:0] iopl;
    } priv_ctx_t;

    typedef struct packed {
        logic flag;
        logic shadow;
    } ie_state_t;

    function automatic ie_cmd_e decode_op(input logic vld, input logic [OP_W-1:0] op);
        if (!vld)
            return CMD_NONE;
        else if (op == OP_SET_IE)
            return CMD_SET;
        else if (op == OP_CLR_IE)
            return CMD_CLR;
        else
            return CMD_NONE;
    endfunction

    function automatic logic priv_ok(input priv_ctx_t c);
        if (!c.pe)
            return 1'b1;
        else if (!c.vm)
            return c.cpl <= c.iopl;
        else
            return c.iopl == PL_LEAST;
    endfunction
endpackage

// File: rtl/ief_decode.sv
module ief_decode
    import ief_pkg::*;
(
    input  logic            retire_vld,
    input  logic [OP_W-1:0] retire_op,
    output ie_cmd_e         cmd,
    output logic            boundary
);
    always_comb begin
        cmd      = decode_op(retire_vld, retire_op);
        boundary = retire_vld;
    end
endmodule

// File: rtl/ief_priv_check.sv
module ief_priv_check
    import ief_pkg::*;
(
    input  ie_cmd_e   cmd,
    input  priv_ctx_t ctx,
    output logic      allow_upd,
    output logic      raise_fault
);
    logic ok;
    logic is_flag_cmd;

    always_comb begin
        ok          = priv_ok(ctx);
        is_flag_cmd = (cmd == CMD_SET) || (cmd == CMD_CLR);
        allow_upd   = is_flag_cmd && ok;
        raise_fault = is_flag_cmd && !ok;
    end
endmodule

// File: rtl/ief_state.sv
module ief_state
    import ief_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             boundary,
    input  ie_cmd_e          cmd,
    input  logic             allow_upd,
    input  logic             raise_fault,
    output ie_state_t        st_q,
    output logic             fault_q,
    output logic [ERR_W-1:0] code_q
);
    ie_state_t st_d;
    logic      fault_d;

    always_comb begin
        st_d    = st_q;
        fault_d = 1'b0;
        if (boundary) begin
            if (raise_fault) begin
                fault_d = 1'b1;
            end else if (allow_upd && cmd == CMD_SET) begin
                st_d.flag   = 1'b1;
                st_d.shadow = !st_q.flag;
            end else if (allow_upd && cmd == CMD_CLR) begin
                st_d.flag   = 1'b0;
                st_d.shadow = 1'b0;
            end else begin
                st_d.shadow = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= '0;
            fault_q <= 1'b0;
            code_q  <= GP_ERR_ZERO;
        end else begin
            st_q    <= st_d;
            fault_q <= fault_d;
            code_q  <= GP_ERR_ZERO;
        end
    end
endmodule

// File: rtl/ief_gate.sv
module ief_gate
    import ief_pkg::*;
(
    input  ie_state_t st,
    input  logic      ext_irq,
    input  logic      nmi_req,
    input  logic      exc_req,
    output logic      take_intr,
    output logic      take_nmi,
    output logic      take_exc
);
    always_comb begin
        take_intr = ext_irq && st.flag && !st.shadow;
        take_nmi  = nmi_req;
        take_exc  = exc_req;
    end
endmodule

// File: rtl/ief_ctrl.sv
module ief_ctrl
    import ief_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             retire_vld,
    input  logic [OP_W-1:0]  retire_op,
    input  logic             prot_en,
    input  logic             virt_mode,
    input  logic [PL_W-1:0]  cpl,
    input  logic [PL_W-1:0]  iopl,
    input  logic             ext_irq,
    input  logic             nmi_req,
    input  logic             exc_req,
    output logic             ie_flag,
    output logic             ie_shadow,
    output logic             take_intr,
    output logic             take_nmi,
    output logic             take_exc,
    output logic             gp_fault,
    output logic [ERR_W-1:0] gp_code
);
    ie_cmd_e   cmd;
    logic      boundary;
    logic      allow_upd;
    logic      raise_fault;
    priv_ctx_t ctx;
    ie_state_t st_q;

    assign ctx = '{pe: prot_en, vm: virt_mode, cpl: cpl, iopl: iopl};

    ief_decode u_dec (
        .retire_vld (retire_vld),
        .retire_op  (retire_op),
        .cmd        (cmd),
        .boundary   (boundary)
    );

    ief_priv_check u_priv (
        .cmd         (cmd),
        .ctx         (ctx),
        .allow_upd   (allow_upd),
        .raise_fault (raise_fault)
    );

    ief_state u_st (
        .clk         (clk),
        .rst         (rst),
        .boundary    (boundary),
        .cmd         (cmd),
        .allow_upd   (allow_upd),
        .raise_fault (raise_fault),
        .st_q        (st_q),
        .fault_q     (gp_fault),
        .code_q      (gp_code)
    );

    ief_gate u_gate (
        .st        (st_q),
        .ext_irq   (ext_irq),
        .nmi_req   (nmi_req),
        .exc_req   (exc_req),
        .take_intr (take_intr),
        .take_nmi  (take_nmi),
        .take_exc  (take_exc)
    );

    assign ie_flag   = st_q.flag;
    assign ie_shadow = st_q.shadow;
endmodule

// File: rtl/ief_ctrl_chk.sv
module ief_ctrl_chk
    import ief_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             retire_vld,
    input logic [OP_W-1:0]  retire_op,
    input logic             ext_irq,
    input logic             nmi_req,
    input logic             exc_req,
    input logic             ie_flag,
    input logic             ie_shadow,
    input logic             take_intr,
    input logic             take_nmi,
    input logic             take_exc,
    input logic             gp_fault,
    input logic [ERR_W-1:0] gp_code
);
    // R3
    shadow_masks_intr_chk: assert property (@(posedge clk) disable iff (rst)
        ie_shadow |-> !take_intr);

    // R3
    intr_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        take_intr |-> (ie_flag && ext_irq));

    // R4
    shadow_starts_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ie_shadow) |-> $rose(ie_flag));

    // R2
    flag_rise_from_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ie_flag) |-> ($past(retire_vld) && $past(retire_op) == OP_SET_IE));

    // R9
    fault_code_zero_chk: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> (gp_code == GP_ERR_ZERO));

    // R9
    fault_keeps_flag_chk: assert property (@(posedge clk) disable iff (rst)
        gp_fault |-> $stable(ie_flag));

    // R10
    nmi_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (take_nmi == nmi_req) && (take_exc == exc_req));

    // R11
    idle_holds_chk: assert property (@(posedge clk) disable iff (rst)
        !retire_vld |=> ($stable(ie_flag) && $stable(ie_shadow)));
endmodule

bind ief_ctrl ief_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .retire_vld (retire_vld),
    .retire_op  (retire_op),
    .ext_irq    (ext_irq),
    .nmi_req    (nmi_req),
    .exc_req    (exc_req),
    .ie_flag    (ie_flag),
    .ie_shadow  (ie_shadow),
    .take_intr  (take_intr),
    .take_nmi   (take_nmi),
    .take_exc   (take_exc),
    .gp_fault   (gp_fault),
    .gp_code    (gp_code)
);

// File: tb/ief_ctrl_test.sv
module ief_ctrl_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        retire_vld = 1'b0;
    logic [7:0]  retire_op = 8'h00;
    logic        prot_en = 1'b0;
    logic        virt_mode = 1'b0;
    logic [1:0]  cpl = 2'd0;
    logic [1:0]  iopl = 2'd0;
    logic        ext_irq = 1'b0;
    logic        nmi_req = 1'b0;
    logic        exc_req = 1'b0;
    logic        ie_flag, ie_shadow, take_intr, take_nmi, take_exc, gp_fault;
    logic [15:0] gp_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    localparam logic [7:0] SETOP = 8'hFB;
    localparam logic [7:0] CLROP = 8'hFA;
    localparam logic [7:0] NOPOP = 8'h90;

    always #5 clk = ~clk;

    ief_ctrl uut (
        .clk(clk), .rst(rst), .retire_vld(retire_vld), .retire_op(retire_op),
        .prot_en(prot_en), .virt_mode(virt_mode), .cpl(cpl), .iopl(iopl),
        .ext_irq(ext_irq), .nmi_req(nmi_req), .exc_req(exc_req),
        .ie_flag(ie_flag), .ie_shadow(ie_shadow), .take_intr(take_intr),
        .take_nmi(take_nmi), .take_exc(take_exc), .gp_fault(gp_fault),
        .gp_code(gp_code)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        retire_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic do_retire(input logic [7:0] op);
        retire_vld = 1'b1;
        retire_op  = op;
        @(negedge clk);
        retire_vld = 1'b0;
        retire_op  = 8'h00;
    endtask

    task automatic set_ctx(input logic pe, input logic vm, input logic [1:0] c, input logic [1:0] i);
        prot_en = pe; virt_mode = vm; cpl = c; iopl = i;
    endtask

    function automatic logic permit(input logic pe, input logic vm, input int c, input int i);
        if (!pe) return 1'b1;
        if (!vm) return c <= i;
        return i == 3;
    endfunction

    function automatic string tag(input logic pe, input logic vm);
        if (!pe) return "R6";
        if (!vm) return "R7";
        return "R8";
    endfunction

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: during reset
        chk("R1", {ie_flag, ie_shadow, take_intr, gp_fault}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", {ie_flag, ie_shadow, take_intr, gp_fault}, 0);

        // Set sweep over every privilege context
        for (int m = 0; m < 64; m++) begin
            logic pe, vm, ok;
            logic [1:0] c, i;
            pe = m[5]; vm = m[4]; c = m[3:2]; i = m[1:0];
            ok = permit(pe, vm, c, i);
            do_reset();
            ext_irq = 1'b1;
            set_ctx(pe, vm, c, i);
            do_retire(SETOP);
            chk(tag(pe, vm), ie_flag, ok);
            chk("R9", {gp_fault, gp_code}, {!ok, 16'h0});
            chk("R3", ie_shadow, ok);
            chk("R3", take_intr, 0);
            do_retire(NOPOP);
            chk("R9", gp_fault, 0);
            chk("R3", ie_shadow, 0);
            chk("R3", take_intr, ok);
        end

        // Clear sweep with the flag already set
        for (int m = 0; m < 64; m++) begin
            logic pe, vm, ok;
            logic [1:0] c, i;
            pe = m[5]; vm = m[4]; c = m[3:2]; i = m[1:0];
            ok = permit(pe, vm, c, i);
            do_reset();
            ext_irq = 1'b1;
            set_ctx(1'b0, 1'b0, 2'd0, 2'd0);
            do_retire(SETOP);
            do_retire(NOPOP);
            set_ctx(pe, vm, c, i);
            do_retire(CLROP);
            chk(tag(pe, vm), ie_flag, !ok);
            chk("R9", gp_fault, !ok);
            chk("R5", take_intr, !ok);
        end

        // R5: clear right after set cancels the window
        do_reset();
        ext_irq = 1'b1;
        set_ctx(1'b1, 1'b0, 2'd0, 2'd0);
        do_retire(SETOP);
        do_retire(CLROP);
        chk("R5", {ie_flag, ie_shadow, take_intr}, 0);
        do_retire(NOPOP);
        chk("R5", take_intr, 0);

        // R4: set with flag already set opens no shadow
        do_retire(SETOP);
        do_retire(NOPOP);
        chk("R4", take_intr, 1);
        do_retire(SETOP);
        chk("R4", {ie_flag, ie_shadow, take_intr}, 3'b101);

        // R9: faulting set keeps shadow and flag, one-cycle pulse
        do_reset();
        set_ctx(1'b1, 1'b0, 2'd0, 2'd0);
        do_retire(SETOP);
        set_ctx(1'b1, 1'b0, 2'd3, 2'd0);
        do_retire(SETOP);
        chk("R9", {ie_flag, ie_shadow, gp_fault}, 3'b111);
        @(negedge clk);
        chk("R9", {ie_flag, ie_shadow, gp_fault}, 3'b110);

        // R11: opcode ignored when not valid; other opcodes keep flag
        do_reset();
        set_ctx(1'b0, 1'b0, 2'd0, 2'd0);
        retire_op = SETOP;
        @(negedge clk);
        @(negedge clk);
        chk("R11", {ie_flag, ie_shadow}, 0);
        retire_op = 8'h00;
        for (int k = 0; k < 256; k++) begin
            if (k != 8'hFB && k != 8'hFA) begin
                do_retire(k[7:0]);
                if (k % 37 == 0) chk("R11", ie_flag, 0);
            end
        end
        do_retire(SETOP);
        do_retire(NOPOP);
        for (int k = 0; k < 256; k++) begin
            if (k != 8'hFB && k != 8'hFA) begin
                do_retire(k[7:0]);
                if (k % 37 == 0) chk("R11", {ie_flag, ie_shadow}, 2'b10);
            end
        end

        // R10: pass-through under every flag/shadow state
        do_reset();
        for (int s = 0; s < 3; s++) begin
            for (int v = 0; v < 4; v++) begin
                nmi_req = v[0]; exc_req = v[1]; ext_irq = v[0];
                #1;
                chk("R10", {take_nmi, take_exc}, {v[0], v[1]});
            end
            do_retire(SETOP);
        end
        nmi_req = 1'b0; exc_req = 1'b0;

        done = 1'b1;
    end

    initial begin
        for (int t = 0; t < 150000; t++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule